// File: doc/BRIEF.md
# XNOR Shift-Register Pattern Source with Optional Full-Length Extension

This block is a pseudo-random pattern source for built-in self-test logic. It is a single shift register whose new low bit comes from an XNOR of its two highest stages. Each enabled clock shifts the state one place towards the most significant bit. The whole register is visible as the output.

A run-time mode input picks one of two sequences. In the short sequence the register walks through every state except all ones, which gives 2^n − 1 states. All ones is the XNOR lockup point: once the register holds it, it stays there.

The long sequence adds one wide AND that recognises the state just before all ones and inverts the feedback bit. The same term first steers the register into all ones and then steers it back out, so all 2^n states occur in each period.

A seed can be loaded at any time, and a load takes priority over stepping. In the short sequence the load clears the lowest seed bit, so the register can never start in the lockup state. In the long sequence the seed is loaded exactly as given.

Top module: `lfsr_gen`

## Requirements
- R1: While reset is asserted, and directly after it, the state output is all zeros.
- R2: In short mode with enable high and load low, the next state is {state[W-2:0], ~(state[W-1] ^ state[W-2])}.
- R3: At width 4 in short mode, a start state other than all ones comes back after exactly 15 steps. The 15 states in that period are all distinct and none of them is 4'hF.
- R4: At width 4 in long mode the period is exactly 16 steps, and the 16 states in it are all distinct.
- R5: A load in short mode stores the seed with bit 0 forced to 0.
- R6: A load in long mode stores the seed unchanged.
- R7: When load is high, the load takes effect in the following cycle whatever the level of enable.
- R8: With enable and load both low, the state holds its value.
- R9: In short mode an all-ones state stays all ones on every step.
- R10: In long mode, the state whose low W-1 bits are all ones and whose top bit is 0 steps to all ones. All ones then steps to all ones with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released in step with the clock |
| en | input | 1 | Advances the register by one step |
| load | input | 1 | Loads the seed, with priority over en |
| ext_mode | input | 1 | 1 selects the 2^n sequence, 0 selects the 2^n − 1 sequence |
| seed | input | WIDTH | Seed value |
| state | output | WIDTH | Current register contents |

## Verification
The bench builds two instances. The first uses WIDTH = 4, which keeps whole periods small enough to walk through. On it the bench counts both period lengths, checks that the states are distinct and that all ones is absent, and runs the lockup and priority cases against a scoreboard model. The second uses WIDTH = 63. On it the bench checks the tap choice and the wide AND term at a width where a full period is far out of reach, by loading the state just before all ones and stepping through the extra state.

// File: rtl/lfsr_pkg.sv
`timescale 1ns/1ps
package lfsr_pkg;

  // Highest feedback stage (bit index, stage 1 = bit 0).
  function automatic int unsigned tap_far(input int unsigned w);
    return w - 1;
  endfunction

  // Second feedback stage; the supported widths use the top two stages.
  function automatic int unsigned tap_near(input int unsigned w);
    case (w)
      4:       return 2;
      63:      return 61;
      default: return w - 2;
    endcase
  endfunction

endpackage

// File: rtl/lfsr_rst_sync.sv
`timescale 1ns/1ps
module lfsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_r <= '0;
    else         sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_r[STAGES-1];
endmodule

// File: rtl/lfsr_feedback.sv
`timescale 1ns/1ps
module lfsr_feedback #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             ext_mode,
  output logic             fb_bit
);
  import lfsr_pkg::*;
  localparam int unsigned FAR  = tap_far(WIDTH);
  localparam int unsigned NEAR = tap_near(WIDTH);

  logic base_fb;
  logic pre_ones;

  always_comb begin
    base_fb  = ~(cur[FAR] ^ cur[NEAR]);
    // State one step before all ones, or all ones itself: low W-1 bits set.
    pre_ones = &cur[WIDTH-2:0];
    fb_bit   = base_fb ^ (ext_mode & pre_ones);
  end
endmodule

// File: rtl/lfsr_seed_guard.sv
`timescale 1ns/1ps
module lfsr_seed_guard #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] seed_in,
  input  logic             ext_mode,
  output logic [WIDTH-1:0] seed_out
);
  always_comb begin
    seed_out = seed_in;
    if (!ext_mode) seed_out[0] = 1'b0;
  end
endmodule

// File: rtl/lfsr_gen.sv
`timescale 1ns/1ps
module lfsr_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             ext_mode,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] ONES     = '1;
  localparam logic [WIDTH-1:0] ONES_LO0 = {{(WIDTH-1){1'b1}}, 1'b0};

  logic             rst_q_n;
  logic             fb_bit;
  logic [WIDTH-1:0] seed_safe;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             q_ce;

  lfsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_q_n(rst_q_n)
  );

  lfsr_feedback #(.WIDTH(WIDTH)) u_fb (
    .cur(q_r), .ext_mode(ext_mode), .fb_bit(fb_bit)
  );

  lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
    .seed_in(seed), .ext_mode(ext_mode), .seed_out(seed_safe)
  );

  // Next-state process
  always_comb begin
    q_ce  = load | en;
    q_nxt = q_r;
    if (load)    q_nxt = seed_safe;
    else if (en) q_nxt = {q_r[WIDTH-2:0], fb_bit};
  end

  // Register process
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  q_r <= '0;
    else if (q_ce) q_r <= q_nxt;
  end

  assign state = q_r;

  a_r3_short_never_enters_ones: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !load && !ext_mode && state != ONES) |=> state != ONES);

  a_r5_short_load_clears_bit0: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load && !ext_mode) |=> state[0] == 1'b0);

  a_r6_long_load_exact: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load && ext_mode) |=> state == $past(seed));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!en && !load) |=> $stable(state));

  a_r9_short_lockup: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !load && !ext_mode && state == ONES) |=> state == ONES);

  a_r10_long_exits_ones: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !load && ext_mode && state == ONES) |=> state == ONES_LO0);
endmodule

// File: tb/sim_lfsr_gen.sv
`timescale 1ns/1ps
module sim_lfsr_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, load, ext_mode;
  logic [3:0] seed;
  logic [3:0] state;

  logic        en1, load1, ext1;
  logic [62:0] seed1;
  logic [62:0] state1;

  int nchk  = 0;
  int nfail = 0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];
  logic [3:0] model_q;

  always #5 clk = ~clk;

  lfsr_gen #(.WIDTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .ext_mode(ext_mode), .seed(seed), .state(state)
  );

  lfsr_gen #(.WIDTH(63)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en1), .load(load1),
    .ext_mode(ext1), .seed(seed1), .state(state1)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference step taken from the requirements (R2, R10).
  function automatic logic [3:0] ref_next(input logic [3:0] q, input bit ext);
    logic fb;
    fb = ~(q[3] ^ q[2]);
    if (ext && q[2:0] == 3'b111) fb = ~fb;
    return {q[2:0], fb};
  endfunction

  // Driver: applies one cycle of inputs and pushes the expected state.
  task automatic drive(input bit e, input bit ld, input logic [3:0] sd,
                       input bit ex, input string tag);
    item_t it;
    @(negedge clk);
    en = e; load = ld; seed = sd; ext_mode = ex;
    if (ld)     model_q = ex ? sd : {sd[3:1], 1'b0};
    else if (e) model_q = ref_next(model_q, ex);
    it.exp = model_q;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares the design's state after each driven edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(state == it.exp, it.tag, {60'd0, state}, {60'd0, it.exp});
      end
    end
  end

  task automatic period_run(input bit ex, input int exp_period, input string tag);
    logic [15:0] seen;
    logic [3:0]  start;
    int          period;
    int          dup;
    seen = '0; period = 0; dup = 0;
    @(negedge clk);
    start = state;
    seen[start] = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      drive(1'b1, 1'b0, 4'h0, ex, tag);
      @(posedge clk);
      #3;
      if (period == 0 && state == start) period = k;
      else if (period == 0) begin
        if (seen[state]) dup++;
        seen[state] = 1'b1;
      end
    end
    chk(period == exp_period, tag, 64'(period), 64'(exp_period));
    chk(dup == 0, tag, 64'(dup), 64'd0);
    chk($countones(seen) == exp_period, tag, 64'($countones(seen)), 64'(exp_period));
    if (!ex) chk(seen[15] == 1'b0, "R3 all ones absent", {63'd0, seen[15]}, 64'd0);
    else     chk(seen[15] == 1'b1, "R4 all ones present", {63'd0, seen[15]}, 64'd1);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; load = 1'b0; ext_mode = 1'b0; seed = '0;
    en1 = 1'b0; load1 = 1'b0; ext1 = 1'b0; seed1 = '0;
    model_q = '0;
    #23;
    @(negedge clk);
    chk(state == 4'h0, "R1 reset u0", {60'd0, state}, 64'd0);
    chk(state1 == '0, "R1 reset u1", {1'b0, state1}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(state == 4'h0, "R1 after release", {60'd0, state}, 64'd0);

    // R2: short-mode stepping from zero
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 4'h0, 1'b0, "R2 step");
    // R8: hold
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 4'h9, 1'b0, "R8 hold");
    // R5: short load masks bit 0
    drive(1'b0, 1'b1, 4'hF, 1'b0, "R5 load F short");
    // R7: load wins over enable
    drive(1'b1, 1'b1, 4'hB, 1'b0, "R7 load priority");
    // R6: long load exact
    drive(1'b0, 1'b1, 4'hF, 1'b1, "R6 load F long");
    // R10: leaving all ones
    drive(1'b1, 1'b0, 4'h0, 1'b1, "R10 exit ones");
    // R10: entering all ones from 0111
    drive(1'b0, 1'b1, 4'h7, 1'b1, "R6 load 7 long");
    drive(1'b1, 1'b0, 4'h0, 1'b1, "R10 enter ones");
    // R9: lockup in short mode
    drive(1'b1, 1'b0, 4'h0, 1'b0, "R9 lockup");
    drive(1'b1, 1'b0, 4'h0, 1'b0, "R9 lockup");
    // R3: short period
    drive(1'b0, 1'b1, 4'h5, 1'b0, "R5 load 5 short");
    period_run(1'b0, 15, "R3 period");
    // R4: long period
    drive(1'b0, 1'b1, 4'h0, 1'b1, "R6 load 0 long");
    period_run(1'b1, 16, "R4 period");
    @(negedge clk);
    en = 1'b0; load = 1'b0;

    // 63-bit instance: taps and wide AND
    @(negedge clk);
    load1 = 1'b1; ext1 = 1'b0; seed1 = '1;
    @(negedge clk);
    chk(state1 == {{62{1'b1}}, 1'b0}, "R5 u1 short load", {1'b0, state1},
        {1'b0, {62{1'b1}}, 1'b0});
    load1 = 1'b1; ext1 = 1'b1; seed1 = {1'b0, {62{1'b1}}};
    @(negedge clk);
    chk(state1 == {1'b0, {62{1'b1}}}, "R6 u1 long load", {1'b0, state1},
        {2'b00, {62{1'b1}}});
    load1 = 1'b0; en1 = 1'b1;
    @(negedge clk);
    chk(state1 == '1, "R10 u1 enter ones", {1'b0, state1}, {1'b0, {63{1'b1}}});
    @(negedge clk);
    chk(state1 == {{62{1'b1}}, 1'b0}, "R10 u1 exit ones", {1'b0, state1},
        {1'b0, {62{1'b1}}, 1'b0});
    ext1 = 1'b0;
    @(negedge clk);
    chk(state1 == {{61{1'b1}}, 2'b01}, "R2 u1 step", {1'b0, state1},
        {1'b0, {61{1'b1}}, 2'b01});
    en1 = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule